// File: doc/BRIEF.md
# Burst Address Counter with Replay

This block is the address generator that sits in front of one port of a synchronous RAM with a 14-bit word address. On each rising clock edge it picks the word address for the coming access from one of four sources. It can take a fresh address from the bus. It can step its counter by one. It can keep the counter where it is. It can jump back to the address that was last taken from the bus. The selected address is registered and drives the array for the access cycle that follows the edge.

A second register keeps the start address of the current burst, which is the last address loaded through the strobe. A replay request copies this register into the counter in a single edge, with no idle cycle between them. A burst can therefore be read or written again from its start while the accesses keep running back to back. The array, the byte lanes and the data path are outside this block.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears `cur_addr` and `base_addr` to 0, whatever the other inputs are.
- R2: With `replay_n` high and `strobe_n` low at an edge, `cur_addr` and `base_addr` both take the value of `ext_addr` after that edge.
- R3: With `replay_n` high, `strobe_n` high and `step_n` low at an edge, `cur_addr` becomes its previous value plus one after that edge.
- R4: Stepping from the top address 0x3FFF wraps `cur_addr` to 0x0000.
- R5: With `replay_n`, `strobe_n` and `step_n` all high, `cur_addr` keeps its value. `ext_addr` has no effect in this case.
- R6: With `replay_n` low at an edge, `cur_addr` takes the value `base_addr` held before the edge, whatever `strobe_n`, `step_n` and `ext_addr` are. `base_addr` does not change.
- R7: `base_addr` changes only through a strobe load under R2 or through reset. Stepping, holding and replay leave it unchanged.
- R8: Replay costs no dead cycle. A step on the edge right after a replay gives the burst start plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | 14 | Address presented on the bus |
| strobe_n | input | 1 | Load `ext_addr`, active low |
| step_n | input | 1 | Advance the counter, active low |
| replay_n | input | 1 | Reload the burst start, active low; highest priority after reset |
| cur_addr | output | 14 | Registered internal address for the access after the edge |
| base_addr | output | 14 | Registered last strobed address (burst start) |

## Verification
Both pieces of state appear directly on the outputs, so a wrong counter value shows on `cur_addr` one edge after the bad decision. A corrupted burst start stays hidden until the next replay copies it to `cur_addr`. For that reason the stimulus replays after steps, after holds and after a wrap, and `base_addr` is also compared on every cycle. A mistake in source priority, such as a strobe overriding a replay or a hold letting `ext_addr` through, shows on the first edge where the conflicting inputs are applied together.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_STEP   = 2'd1,
        SRC_LOAD   = 2'd2,
        SRC_REPLAY = 2'd3
    } addr_src_e;

endpackage

// File: rtl/burst_src_sel.sv
module burst_src_sel
    import burst_addr_pkg::*;
(
    input  logic      strobe_n,
    input  logic      step_n,
    input  logic      replay_n,
    output addr_src_e src
);
    // Priority: replay over strobe over step over hold
    always_comb begin
        if (!replay_n)      src = SRC_REPLAY;
        else if (!strobe_n) src = SRC_LOAD;
        else if (!step_n)   src = SRC_STEP;
        else                src = SRC_HOLD;
    end
endmodule

// File: rtl/burst_next_addr.sv
module burst_next_addr
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  addr_src_e         src,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic [ADDR_W-1:0] cur_q,
    input  logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] cur_d,
    output logic [ADDR_W-1:0] base_d
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    always_comb begin
        cur_d  = cur_q;
        base_d = base_q;
        unique case (src)
            SRC_REPLAY: cur_d = base_q;
            SRC_LOAD: begin
                cur_d  = ext_addr;
                base_d = ext_addr;
            end
            SRC_STEP:   cur_d = cur_q + ONE;   // natural wrap at the top
            default:    cur_d = cur_q;
        endcase
    end
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              strobe_n,
    input  logic              step_n,
    input  logic              replay_n,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [ADDR_W-1:0] base_addr
);
    typedef struct packed {
        logic [ADDR_W-1:0] cur;
        logic [ADDR_W-1:0] base;
    } state_t;

    state_t    state_d, state_q;
    addr_src_e src;
    logic [ADDR_W-1:0] cur_nx, base_nx;

    burst_src_sel u_sel (
        .strobe_n (strobe_n),
        .step_n   (step_n),
        .replay_n (replay_n),
        .src      (src)
    );

    burst_next_addr #(.ADDR_W(ADDR_W)) u_next (
        .src      (src),
        .ext_addr (ext_addr),
        .cur_q    (state_q.cur),
        .base_q   (state_q.base),
        .cur_d    (cur_nx),
        .base_d   (base_nx)
    );

    always_comb begin
        state_d      = state_q;
        state_d.cur  = cur_nx;
        state_d.base = base_nx;
        if (rst) state_d = '0;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign cur_addr  = state_q.cur;
    assign base_addr = state_q.base;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 14
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] ext_addr,
    input logic              strobe_n,
    input logic              step_n,
    input logic              replay_n,
    input logic [ADDR_W-1:0] cur_addr,
    input logic [ADDR_W-1:0] base_addr
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] TOP = '1;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && base_addr == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (rst)
        (replay_n && !strobe_n) |=> (cur_addr == $past(ext_addr) && base_addr == $past(ext_addr)));

    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        (replay_n && strobe_n && !step_n) |=> (cur_addr == $past(cur_addr) + ONE));

    p_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (replay_n && strobe_n && !step_n && cur_addr == TOP) |=> (cur_addr == '0));

    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (replay_n && strobe_n && step_n) |=> $stable(cur_addr));

    p_replay_r6: assert property (@(posedge clk) disable iff (rst)
        !replay_n |=> (cur_addr == $past(base_addr) && $stable(base_addr)));

    p_base_only_load_r7: assert property (@(posedge clk) disable iff (rst)
        (strobe_n || !replay_n) |=> $stable(base_addr));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ext_addr  (ext_addr),
    .strobe_n  (strobe_n),
    .step_n    (step_n),
    .replay_n  (replay_n),
    .cur_addr  (cur_addr),
    .base_addr (base_addr)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int  ADDR_W = 14;
    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 14;

    typedef struct packed {
        logic              strobe_n;
        logic              step_n;
        logic              replay_n;
        logic [ADDR_W-1:0] ext;
        logic [ADDR_W-1:0] exp_cur;
        logic [ADDR_W-1:0] exp_base;
        logic [3:0]        req;
    } vec_t;

    // Each row is applied for one edge; the result is checked before the next row
    localparam vec_t VEC [NVEC] = '{
        '{1'b0, 1'b1, 1'b1, 14'h1234, 14'h1234, 14'h1234, 4'd2},
        '{1'b1, 1'b0, 1'b1, 14'h0000, 14'h1235, 14'h1234, 4'd3},
        '{1'b1, 1'b0, 1'b1, 14'h0101, 14'h1236, 14'h1234, 4'd3},
        '{1'b1, 1'b1, 1'b1, 14'h0000, 14'h1236, 14'h1234, 4'd5},
        '{1'b1, 1'b1, 1'b1, 14'h0AAA, 14'h1236, 14'h1234, 4'd5},
        '{1'b0, 1'b0, 1'b0, 14'h2222, 14'h1234, 14'h1234, 4'd6},
        '{1'b1, 1'b0, 1'b1, 14'h3333, 14'h1235, 14'h1234, 4'd8},
        '{1'b1, 1'b0, 1'b0, 14'h0000, 14'h1234, 14'h1234, 4'd6},
        '{1'b0, 1'b1, 1'b1, 14'h3FFE, 14'h3FFE, 14'h3FFE, 4'd2},
        '{1'b1, 1'b0, 1'b1, 14'h0000, 14'h3FFF, 14'h3FFE, 4'd3},
        '{1'b1, 1'b0, 1'b1, 14'h0000, 14'h0000, 14'h3FFE, 4'd4},
        '{1'b1, 1'b1, 1'b1, 14'h1111, 14'h0000, 14'h3FFE, 4'd7},
        '{1'b1, 1'b1, 1'b0, 14'h0000, 14'h3FFE, 14'h3FFE, 4'd6},
        '{1'b0, 1'b0, 1'b1, 14'h0000, 14'h0000, 14'h0000, 4'd2}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic              strobe_n = 1'b1;
    logic              step_n = 1'b1;
    logic              replay_n = 1'b1;
    logic [ADDR_W-1:0] cur_addr, base_addr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .ext_addr  (ext_addr),
        .strobe_n  (strobe_n),
        .step_n    (step_n),
        .replay_n  (replay_n),
        .cur_addr  (cur_addr),
        .base_addr (base_addr)
    );

    task automatic check(input string req, input logic [ADDR_W-1:0] exp_cur,
                         input logic [ADDR_W-1:0] exp_base);
        checks++;
        if (cur_addr !== exp_cur || base_addr !== exp_base) begin
            failures++;
            $display("FAIL %s: cur=%h base=%h expected cur=%h base=%h",
                     req, cur_addr, base_addr, exp_cur, exp_base);
        end
    endtask

    task automatic drive(input logic s, input logic e, input logic r,
                         input logic [ADDR_W-1:0] a);
        strobe_n = s;
        step_n   = e;
        replay_n = r;
        ext_addr = a;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            finish_run();
        end
    end

    initial begin
        // R1: reset while the strobe asks for a load
        drive(1'b0, 1'b1, 1'b1, 14'h1555);
        repeat (2) @(negedge clk);
        check("R1 reset state", '0, '0);
        rst = 1'b0;
        drive(VEC[0].strobe_n, VEC[0].step_n, VEC[0].replay_n, VEC[0].ext);
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].exp_cur, VEC[i].exp_base);
            if (i + 1 < NVEC)
                drive(VEC[i+1].strobe_n, VEC[i+1].step_n, VEC[i+1].replay_n, VEC[i+1].ext);
        end

        // R8: long run of steps, then replay, then step again with no gap
        drive(1'b0, 1'b1, 1'b1, 14'h0100);
        @(negedge clk);
        drive(1'b1, 1'b0, 1'b1, 14'h0000);
        repeat (5) @(negedge clk);
        check("R3 five steps", 14'h0105, 14'h0100);
        drive(1'b1, 1'b1, 1'b0, 14'h0000);
        @(negedge clk);
        check("R6 replay after steps", 14'h0100, 14'h0100);
        drive(1'b1, 1'b0, 1'b1, 14'h0000);
        @(negedge clk);
        check("R8 step right after replay", 14'h0101, 14'h0100);
        // R7: replay with strobe low must not reload base from the bus
        drive(1'b0, 1'b1, 1'b0, 14'h0777);
        @(negedge clk);
        check("R7 base kept under replay", 14'h0100, 14'h0100);

        // R1: reset in the middle of a burst
        drive(1'b1, 1'b0, 1'b1, 14'h0000);
        rst = 1'b1;
        @(negedge clk);
        check("R1 mid-run reset", '0, '0);
        rst = 1'b0;
        @(negedge clk);
        check("R3 step from reset value", 14'h0001, '0);

        done = 1'b1;
        finish_run();
    end
endmodule